// File: doc/BRIEF.md
# Find First Set/Clear Unit

This block searches a bit field held in a register for the first bit that is in a requested state, either one or zero. The field lies inside a `DATA_W`-bit base word. A start position gives the lowest bit of the field and a size gives its width. The scan begins at the lowest bit of the field and moves toward its highest bit. The result is a position counted from bit 0 of the base word. If no bit in the field has the requested state, the result is the position just above the field. A zero-bit field returns the start position unchanged.

A request is a single-cycle `start` pulse carrying an opcode, start position, size and base word. The answer is computed combinationally and registered, so the latency is fixed at one clock. `done` rises in the cycle after `start`, and `findpos`, the condition codes and `fault` are valid while `done` is high. A new request may be issued in every cycle.

The controller has two states:
- `ST_IDLE`: no result is being presented.
- `ST_DONE`: a result is presented.

The transitions are:
- `ST_IDLE` to `ST_DONE` on `start`.
- `ST_DONE` to `ST_DONE` on a back-to-back `start`.
- `ST_DONE` to `ST_IDLE` when `start` is low.

Top module: `ffs_unit`

## Requirements
- R1: Opcode 8'hEA searches for a set bit. When the field holds a one, `findpos` becomes that bit's index counted from bit 0 of `base`, and `cc_z` is 0.
- R2: Opcode 8'hEB searches for a clear bit. When the field holds a zero, `findpos` becomes that bit's index counted from bit 0 of `base`, and `cc_z` is 0.
- R3: Only bits `startpos` to `startpos+size-1` take part in the search. When several bits match, the lowest-indexed one is reported. Bits outside the field never affect the result.
- R4: When no bit of a non-empty field matches, `findpos` becomes `startpos+size` and `cc_z` is 1.
- R5: When `size` is 0, `findpos` becomes `startpos` and `cc_z` is 1. This case is not a fault as long as `startpos` is at most `DATA_W`.
- R6: `cc_n`, `cc_v` and `cc_c` are 0 after every request.
- R7: `fault` is raised together with `done` in three cases: `size` > `DATA_W`, `startpos+size` > `DATA_W` (computed without wrap-around), or an opcode other than 8'hEA or 8'hEB. On a faulting request, `findpos` and the condition codes keep their previous values. `fault` is 0 whenever `done` is 0.
- R8: `done` is high in exactly the cycles that follow a cycle in which `start` was high. A lone request therefore gives a one-cycle pulse, and back-to-back requests each get their own result cycle.
- R9: After reset, `findpos` is 0, all condition codes are 0, and `fault` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, one cycle per request |
| opcode | input | 8 | 8'hEA find set, 8'hEB find clear |
| startpos | input | POS_W (32) | Lowest bit of the field |
| size | input | SIZE_W (8) | Field width in bits |
| base | input | DATA_W (32) | Word holding the field |
| findpos | output | POS_W (32) | Found position, or limit position |
| cc_n | output | 1 | Negative flag, always 0 |
| cc_z | output | 1 | Set when no matching bit was found |
| cc_v | output | 1 | Overflow flag, always 0 |
| cc_c | output | 1 | Carry flag, always 0 |
| fault | output | 1 | Reserved-operand fault for this result |
| done | output | 1 | Result valid |

## Verification
The assertions check several properties on every cycle:
- the one-clock latency of `done` and the absence of extra pulses;
- that N, V and C stay clear;
- that a fault only appears with `done` and leaves `findpos` and Z untouched;
- that a not-found result equals the registered start position plus size;
- that the field window is exactly `size` bits wide;
- that the encoder reports the lowest hit.

Only the bench scenarios can show the rest. This covers the actual positions found for set and clear searches, and that bits outside the field are ignored. It also covers the edge values: a zero-size field at position 32, full-width fields, overflowing start positions and illegal opcodes. These are compared against an independent model over directed and random requests.

// File: rtl/ffs_pkg.sv
package ffs_pkg;
    localparam logic [7:0] OPC_FIND_SET = 8'hEA;
    localparam logic [7:0] OPC_FIND_CLR = 8'hEB;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } ffs_state_t;
endpackage

// File: rtl/ffs_field_window.sv
module ffs_field_window #(
    parameter int DATA_W = 32,
    parameter int POS_W  = 32,
    parameter int SIZE_W = 8
) (
    input  logic [POS_W-1:0]  startpos,
    input  logic [SIZE_W-1:0] size,
    output logic [DATA_W-1:0] mask,
    output logic [POS_W-1:0]  limit_pos,
    output logic              range_err
);
    localparam int EXT_W = POS_W + 1;

    logic [EXT_W-1:0] ext_start;
    logic [EXT_W-1:0] ext_limit;

    assign ext_start = {1'b0, startpos};
    assign ext_limit = ext_start + EXT_W'(size);
    assign limit_pos = ext_limit[POS_W-1:0];

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        localparam logic [EXT_W-1:0] BIT_IDX = EXT_W'(i);
        assign mask[i] = (ext_start <= BIT_IDX) && (BIT_IDX < ext_limit);
    end

    always_comb begin
        range_err = (int'(size) > DATA_W) || (ext_limit > EXT_W'(DATA_W));
    end

    always_comb begin
        if (!range_err) begin
            assert_window_width_R3: assert ($countones(mask) == int'(size))
                else $error("field window width differs from size");
        end
    end
endmodule

// File: rtl/ffs_low_encoder.sv
module ffs_low_encoder #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] hits,
    output logic              found,
    output logic [IDX_W-1:0]  idx
);
    logic [DATA_W-1:0] below;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (hits[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
        below = hits & ~({DATA_W{1'b1}} << idx);
        if (found) begin
            assert_lowest_hit_R3: assert (hits[idx] && (below == '0))
                else $error("encoder did not report the lowest hit");
        end
    end
endmodule

// File: rtl/ffs_unit.sv
module ffs_unit
    import ffs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int POS_W  = 32,
    parameter int SIZE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [POS_W-1:0]  startpos,
    input  logic [SIZE_W-1:0] size,
    input  logic [DATA_W-1:0] base,
    output logic [POS_W-1:0]  findpos,
    output logic              cc_n,
    output logic              cc_z,
    output logic              cc_v,
    output logic              cc_c,
    output logic              fault,
    output logic              done
);
    localparam int IDX_W = $clog2(DATA_W);

    ffs_state_t state_q, state_d;

    logic [DATA_W-1:0] field_mask;
    logic [DATA_W-1:0] search_vec;
    logic [DATA_W-1:0] hits;
    logic [POS_W-1:0]  limit_pos;
    logic [POS_W-1:0]  next_pos;
    logic [IDX_W-1:0]  hit_idx;
    logic              range_err;
    logic              bad_op;
    logic              hit_found;
    logic              req_fault;

    ffs_field_window #(
        .DATA_W (DATA_W),
        .POS_W  (POS_W),
        .SIZE_W (SIZE_W)
    ) i_window (
        .startpos  (startpos),
        .size      (size),
        .mask      (field_mask),
        .limit_pos (limit_pos),
        .range_err (range_err)
    );

    always_comb begin
        bad_op     = (opcode != OPC_FIND_SET) && (opcode != OPC_FIND_CLR);
        search_vec = (opcode == OPC_FIND_CLR) ? ~base : base;
        hits       = search_vec & field_mask;
        req_fault  = bad_op || range_err;
    end

    ffs_low_encoder #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) i_encoder (
        .hits  (hits),
        .found (hit_found),
        .idx   (hit_idx)
    );

    assign next_pos = hit_found ? POS_W'(hit_idx) : limit_pos;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)  state_d = ST_DONE;
            ST_DONE: if (!start) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign done = (state_q == ST_DONE);

    // Result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            findpos <= '0;
            cc_n    <= 1'b0;
            cc_z    <= 1'b0;
            cc_v    <= 1'b0;
            cc_c    <= 1'b0;
            fault   <= 1'b0;
        end else if (start) begin
            fault <= req_fault;
            if (!req_fault) begin
                findpos <= next_pos;
                cc_z    <= !hit_found;
                cc_n    <= 1'b0;
                cc_v    <= 1'b0;
                cc_c    <= 1'b0;
            end
        end else begin
            fault <= 1'b0;
        end
    end

    assert_done_follows_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    assert_done_no_extra_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
    assert_nvc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(cc_n || cc_v || cc_c));
    assert_fault_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done);
    assert_fault_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ($stable(findpos) && $stable(cc_z)));
    assert_notfound_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !req_fault && !hit_found) |=>
            (findpos == POS_W'({1'b0, $past(startpos)} + (POS_W+1)'($past(size)))));
endmodule

// File: tb/test_ffs_unit.sv
module test_ffs_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [31:0] startpos = '0;
    logic [7:0]  size = '0;
    logic [31:0] base = '0;
    logic [31:0] findpos;
    logic        cc_n, cc_z, cc_v, cc_c, fault, done;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [31:0] exp_pos = '0;
    logic        exp_z = 1'b0;
    logic        exp_fault = 1'b0;
    string       exp_tag = "R1";

    always #4 clk = ~clk;

    ffs_unit i_ffs_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .startpos(startpos), .size(size), .base(base), .findpos(findpos),
        .cc_n(cc_n), .cc_z(cc_z), .cc_v(cc_v), .cc_c(cc_c),
        .fault(fault), .done(done)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model(input logic [7:0] op, input logic [31:0] sp,
                         input logic [7:0] sz, input logic [31:0] b);
        longint lim;
        lim = longint'(sp) + longint'(sz);
        if ((op != 8'hEA && op != 8'hEB) || sz > 32 || lim > 32) begin
            exp_fault = 1'b1;
            exp_tag = "R7";
        end else begin
            exp_fault = 1'b0;
            exp_pos = 32'(lim);
            exp_z = 1'b1;
            for (longint i = longint'(sp); i < lim; i++) begin
                if (b[i] == (op == 8'hEA)) begin
                    exp_pos = 32'(i);
                    exp_z = 1'b0;
                    break;
                end
            end
            if (sz == 0) exp_tag = "R5";
            else if (exp_z) exp_tag = "R4";
            else if (op == 8'hEA) exp_tag = "R1";
            else exp_tag = "R2";
        end
    endtask

    task automatic drive(input logic [7:0] op, input logic [31:0] sp,
                         input logic [7:0] sz, input logic [31:0] b);
        opcode = op; startpos = sp; size = sz; base = b; start = 1'b1;
        model(op, sp, sz, b);
    endtask

    task automatic check_result(input string tag);
        check("R8", "done", 64'(done), 64'(1));
        check(exp_fault ? "R7" : tag, "fault", 64'(fault), 64'(exp_fault));
        check(tag, "findpos", 64'(findpos), 64'(exp_pos));
        check(tag, "cc_z", 64'(cc_z), 64'(exp_z));
        check("R6", "nvc", 64'({cc_n, cc_v, cc_c}), 64'(0));
    endtask

    task automatic do_op(input string tag, input logic [7:0] op, input logic [31:0] sp,
                         input logic [7:0] sz, input logic [31:0] b);
        @(negedge clk);
        check("R8", "idle done", 64'(done), 64'(0));
        check("R7", "idle fault", 64'(fault), 64'(0));
        drive(op, sp, sz, b);
        @(negedge clk);
        check_result(tag == "" ? exp_tag : tag);
        start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  r_op;
        logic [31:0] r_sp, r_b;
        logic [7:0]  r_sz;
        int seed;
        seed = 12345;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check("R9", "reset findpos", 64'(findpos), 64'(0));
        check("R9", "reset flags", 64'({cc_n, cc_z, cc_v, cc_c}), 64'(0));
        check("R9", "reset fault/done", 64'({fault, done}), 64'(0));
        rst_n = 1'b1;

        do_op("R1", 8'hEA, 32'd4, 8'd8, 32'h0000_0100);
        do_op("R2", 8'hEB, 32'd0, 8'd32, 32'hFFFF_FFF7);
        do_op("R3", 8'hEA, 32'd8, 8'd8, 32'h0000_A0FF);
        do_op("R3", 8'hEA, 32'd0, 8'd4, 32'hFFFF_FFF0);
        do_op("R4", 8'hEB, 32'd28, 8'd4, 32'hFFFF_FFFF);
        do_op("R1", 8'hEA, 32'd0, 8'd32, 32'h8000_0000);
        do_op("R5", 8'hEA, 32'd17, 8'd0, 32'hFFFF_FFFF);
        do_op("R5", 8'hEB, 32'd32, 8'd0, 32'h0000_0000);
        do_op("R1", 8'hEA, 32'd3, 8'd5, 32'h0000_0010);
        do_op("R7", 8'hEA, 32'd30, 8'd3, 32'hFFFF_FFFF);
        do_op("R7", 8'hEB, 32'd0, 8'd33, 32'h0000_0000);
        do_op("R7", 8'h55, 32'd0, 8'd8, 32'h0000_0001);
        do_op("R7", 8'hEA, 32'hFFFF_FFF0, 8'd32, 32'h0000_0001);
        do_op("R7", 8'hEB, 32'd33, 8'd0, 32'h0000_0000);

        // back-to-back requests (R8)
        @(negedge clk);
        drive(8'hEA, 32'd0, 8'd16, 32'h0000_0200);
        @(negedge clk);
        check_result("R8");
        drive(8'hEB, 32'd5, 8'd10, 32'h0000_0000);
        @(negedge clk);
        check_result("R8");
        start = 1'b0;
        @(negedge clk);
        check("R8", "pulse ends", 64'(done), 64'(0));

        for (int k = 0; k < 400; k++) begin
            r_op = ($urandom % 8 == 0) ? 8'($urandom) : (($urandom % 2) ? 8'hEA : 8'hEB);
            r_sz = ($urandom % 10 == 0) ? 8'($urandom) : 8'($urandom % 35);
            r_sp = ($urandom % 20 == 0) ? $urandom : ($urandom % 34);
            case ($urandom % 4)
                0: r_b = 32'h0;
                1: r_b = 32'hFFFF_FFFF;
                default: r_b = $urandom;
            endcase
            do_op("", r_op, r_sp, r_sz, r_b);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule